// File: doc/BRIEF.md
# Paired-instruction fetch sequencer

This block is the fetch and sequencing front end of a small accumulator machine whose memory words each carry two instructions. A word is 40 bits wide and holds a left instruction and a right instruction. Each instruction has an 8-bit opcode and a 12-bit operand address. The program counter names a word, which is an instruction pair, and not a single instruction. The sequencer loads the counter into its memory address register and reads one word into its memory buffer register. It issues the left instruction at once and keeps the right instruction in a one-entry buffer.

Instructions go one at a time to a downstream execute stage over a valid/opcode/address interface. When the left instruction completes, the right one comes from the buffer and needs no second memory access. The execute stage can redirect the flow with a jump. A jump carries a target word and a half-select bit. When the right half is selected, only the right instruction of the target word is issued.

Memory is a 4096-word, word-addressed store. It returns read data one cycle after a read strobe, together with a valid strobe.

Top module: `fetch_pair_seq`

## Requirements
- R1: Bit 39 of a memory word is its first bit. The left opcode is bits 39:32 and the left address is bits 31:20. The right opcode is bits 19:12 and the right address is bits 11:0.
- R2: While rst_ni is low, disp_valid_o is 0 and pc_o is 0. The first read after reset is issued on mem_rd_o at address 0.
- R3: Every fetch is a single-cycle pulse on mem_rd_o with mem_addr_o equal to the word being fetched. No instruction is dispatched while a read is being issued.
- R4: Without jumps, instructions are dispatched in the order left then right of each word, with words in ascending address order. disp_right_o is 0 for a left instruction and 1 for a right instruction.
- R5: After a left instruction completes, the right instruction of the same word is dispatched in the next cycle and no memory read takes place.
- R6: pc_o advances by one for each word fetched and wraps from 4095 to 0. While an instruction from word W is dispatched without a jump in flight, pc_o equals W+1.
- R7: A jump with half-select 0 discards any buffered instruction. It fetches the target word and dispatches its left instruction, then its right instruction.
- R8: A jump with half-select 1 fetches the target word and dispatches only its right instruction. The left instruction of the next word follows.
- R9: While disp_valid_o is 1 and neither exec_done_i nor exec_jump_i is asserted, the dispatched opcode, address and half flag hold steady.
- R10: When exec_jump_i and exec_done_i are asserted together, the jump wins and the buffered instruction is not dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_rd_o | output | 1 | Memory read strobe, one cycle per fetch |
| mem_addr_o | output | 12 | Word address (memory address register) |
| mem_rdata_i | input | 40 | Read data word |
| mem_rvalid_i | input | 1 | Read data valid |
| disp_valid_o | output | 1 | An instruction is presented to execute |
| disp_opcode_o | output | 8 | Dispatched opcode |
| disp_addr_o | output | 12 | Dispatched operand address |
| disp_right_o | output | 1 | 1 when the dispatched instruction is a right half |
| exec_done_i | input | 1 | Execute has finished the dispatched instruction |
| exec_jump_i | input | 1 | Execute requests a jump |
| jump_target_i | input | 12 | Jump target word |
| jump_right_i | input | 1 | Jump half-select, 1 selects the right instruction |
| pc_o | output | 12 | Program counter, the next word to fetch |

## Verification
The bench walks through forty consecutive words, and every word's content is a computed function of its address. A design that swapped or misaligned the halves would then show the wrong opcode or address on the first word. It counts memory strobes between the left and right dispatch of each word, so a sequencer that refetched for the right half is caught. It jumps to word 4094 to run across the 4095-to-0 wrap of the counter, and it sweeps right-half jumps across the address space to catch a sequencer that issues the skipped left instruction. It also raises done and jump together while an instruction sits in the buffer: a design that gave done priority would issue the stale right instruction.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;
  parameter int unsigned OP_W = 8;
  parameter int unsigned AD_W = 12;
  localparam int unsigned INSTR_W = OP_W + AD_W;
  localparam int unsigned WORD_W  = 2 * INSTR_W;

  typedef struct packed {
    logic [OP_W-1:0] op;
    logic [AD_W-1:0] addr;
  } instr_t;

  typedef enum logic [1:0] {
    ST_READ,
    ST_WAIT,
    ST_LOAD,
    ST_EXEC
  } state_e;
endpackage

// File: rtl/fps_split.sv
`timescale 1ns/1ps
module fps_split
  import fps_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output instr_t            left_o,
  output instr_t            right_o
);
  // first instruction sits in the upper half
  assign left_o  = instr_t'(word_i[WORD_W-1 -: INSTR_W]);
  assign right_o = instr_t'(word_i[INSTR_W-1:0]);
endmodule

// File: rtl/fps_pc.sv
`timescale 1ns/1ps
module fps_pc
  import fps_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            load_i,
  input  logic [AD_W-1:0] load_val_i,
  output logic [AD_W-1:0] pc_o
);
  logic [AD_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (load_i) begin
      pc_q <= load_val_i;
    end else if (inc_i) begin
      pc_q <= pc_q + AD_W'(1);
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/fps_ibr.sv
`timescale 1ns/1ps
module fps_ibr
  import fps_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fill_i,
  input  instr_t fill_val_i,
  input  logic   drop_i,
  output instr_t ibr_o,
  output logic   valid_o
);
  instr_t ibr_q;
  logic   valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibr_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (fill_i) ibr_q <= fill_val_i;
      if (drop_i) valid_q <= 1'b0;
      else if (fill_i) valid_q <= 1'b1;
    end
  end

  assign ibr_o   = ibr_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/fetch_pair_seq.sv
`timescale 1ns/1ps
module fetch_pair_seq
  import fps_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_rd_o,
  output logic [AD_W-1:0]   mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic              disp_valid_o,
  output logic [OP_W-1:0]   disp_opcode_o,
  output logic [AD_W-1:0]   disp_addr_o,
  output logic              disp_right_o,
  input  logic              exec_done_i,
  input  logic              exec_jump_i,
  input  logic [AD_W-1:0]   jump_target_i,
  input  logic              jump_right_i,
  output logic [AD_W-1:0]   pc_o
);
  state_e            state_q;
  logic [AD_W-1:0]   mar_q;
  logic [WORD_W-1:0] mbr_q;
  logic [OP_W-1:0]   ir_q;
  logic [AD_W-1:0]   ar_q;
  logic              half_q;
  logic              skip_left_q;

  instr_t left_w, right_w, ibr_w;
  logic   ibr_valid;
  logic   take_jump, take_done, use_buf;
  logic   pc_inc, ibr_fill, ibr_drop;
  logic [AD_W-1:0] pc_w;

  fps_split u_split (
    .word_i  (mbr_q),
    .left_o  (left_w),
    .right_o (right_w)
  );

  always_comb begin
    take_jump = (state_q == ST_EXEC) && exec_jump_i;
    take_done = (state_q == ST_EXEC) && exec_done_i && !exec_jump_i;
    use_buf   = take_done && ibr_valid;
    pc_inc    = (state_q == ST_LOAD);
    ibr_fill  = (state_q == ST_LOAD) && !skip_left_q;
    ibr_drop  = take_jump || use_buf;
  end

  fps_pc u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (pc_inc),
    .load_i     (take_jump),
    .load_val_i (jump_target_i),
    .pc_o       (pc_w)
  );

  fps_ibr u_ibr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_i     (ibr_fill),
    .fill_val_i (right_w),
    .drop_i     (ibr_drop),
    .ibr_o      (ibr_w),
    .valid_o    (ibr_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_READ;
      mar_q       <= '0;
      mbr_q       <= '0;
      ir_q        <= '0;
      ar_q        <= '0;
      half_q      <= 1'b0;
      skip_left_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_READ: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            mbr_q   <= mem_rdata_i;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (skip_left_q) begin
            ir_q   <= right_w.op;
            ar_q   <= right_w.addr;
            half_q <= 1'b1;
          end else begin
            ir_q   <= left_w.op;
            ar_q   <= left_w.addr;
            half_q <= 1'b0;
          end
          skip_left_q <= 1'b0;
          state_q     <= ST_EXEC;
        end
        ST_EXEC: begin
          if (take_jump) begin
            mar_q       <= jump_target_i;
            skip_left_q <= jump_right_i;
            state_q     <= ST_READ;
          end else if (use_buf) begin
            ir_q   <= ibr_w.op;
            ar_q   <= ibr_w.addr;
            half_q <= 1'b1;
          end else if (take_done) begin
            mar_q   <= pc_w;
            state_q <= ST_READ;
          end
        end
        default: state_q <= ST_READ;
      endcase
    end
  end

  assign mem_rd_o      = (state_q == ST_READ);
  assign mem_addr_o    = mar_q;
  assign disp_valid_o  = (state_q == ST_EXEC);
  assign disp_opcode_o = ir_q;
  assign disp_addr_o   = ar_q;
  assign disp_right_o  = half_q;
  assign pc_o          = pc_w;
endmodule

// File: rtl/fps_checks.sv
`timescale 1ns/1ps
module fps_checks
  import fps_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_rd_o,
  input logic [AD_W-1:0] mem_addr_o,
  input logic            disp_valid_o,
  input logic [OP_W-1:0] disp_opcode_o,
  input logic [AD_W-1:0] disp_addr_o,
  input logic            disp_right_o,
  input logic            exec_done_i,
  input logic            exec_jump_i,
  input logic [AD_W-1:0] jump_target_i,
  input logic [AD_W-1:0] pc_o
);
  assert_rd_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  assert_no_disp_on_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !disp_valid_o);

  assert_right_no_mem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && exec_done_i && !exec_jump_i && !disp_right_o)
      |=> (disp_valid_o && disp_right_o && !mem_rd_o));

  assert_jump_fetch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && exec_jump_i)
      |=> (mem_rd_o && mem_addr_o == $past(jump_target_i) && pc_o == $past(jump_target_i)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && !exec_done_i && !exec_jump_i)
      |=> (disp_valid_o && $stable(disp_opcode_o) && $stable(disp_addr_o) && $stable(disp_right_o)));

  assert_jump_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_o && exec_jump_i && exec_done_i) |=> !disp_valid_o);
endmodule

bind fetch_pair_seq fps_checks u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_rd_o      (mem_rd_o),
  .mem_addr_o    (mem_addr_o),
  .disp_valid_o  (disp_valid_o),
  .disp_opcode_o (disp_opcode_o),
  .disp_addr_o   (disp_addr_o),
  .disp_right_o  (disp_right_o),
  .exec_done_i   (exec_done_i),
  .exec_jump_i   (exec_jump_i),
  .jump_target_i (jump_target_i),
  .pc_o          (pc_o)
);

// File: tb/sim_fetch_pair_seq.sv
`timescale 1ns/1ps
module sim_fetch_pair_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd, mem_rvalid = 1'b0;
  logic [11:0] mem_addr;
  logic [39:0] mem_rdata = '0;
  logic        disp_valid, disp_right;
  logic [7:0]  disp_op;
  logic [11:0] disp_addr, pc;
  logic        exec_done = 1'b0, exec_jump = 1'b0, jump_right = 1'b0;
  logic [11:0] jump_target = '0;

  int checks = 0;
  int fails  = 0;
  int reads  = 0;

  always #4 clk = ~clk; // 125 MHz

  fetch_pair_seq u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .mem_rd_o      (mem_rd),
    .mem_addr_o    (mem_addr),
    .mem_rdata_i   (mem_rdata),
    .mem_rvalid_i  (mem_rvalid),
    .disp_valid_o  (disp_valid),
    .disp_opcode_o (disp_op),
    .disp_addr_o   (disp_addr),
    .disp_right_o  (disp_right),
    .exec_done_i   (exec_done),
    .exec_jump_i   (exec_jump),
    .jump_target_i (jump_target),
    .jump_right_i  (jump_right),
    .pc_o          (pc)
  );

  function automatic logic [7:0]  l_op(input logic [11:0] a); return a[7:0] ^ 8'h5A; endfunction
  function automatic logic [11:0] l_ad(input logic [11:0] a); return a ^ 12'h111;    endfunction
  function automatic logic [7:0]  r_op(input logic [11:0] a); return a[7:0] ^ 8'hA5; endfunction
  function automatic logic [11:0] r_ad(input logic [11:0] a); return ~a;             endfunction

  // memory model: one-cycle latency, first field in bit 39 (R1)
  always @(posedge clk) begin
    if (rst_n && mem_rd) begin
      reads      <= reads + 1;
      mem_rvalid <= 1'b1;
      mem_rdata  <= {l_op(mem_addr), l_ad(mem_addr), r_op(mem_addr), r_ad(mem_addr)};
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic expect_disp(input logic [11:0] w, input bit right, input string req);
    logic [7:0]  eop;
    logic [11:0] ead;
    int n = 0;
    while (!disp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    eop = right ? r_op(w) : l_op(w);
    ead = right ? r_ad(w) : l_ad(w);
    chk(disp_valid == 1'b1, req, 40'(disp_valid), 40'd1);
    chk(disp_op == eop, req, 40'(disp_op), 40'(eop));
    chk(disp_addr == ead, req, 40'(disp_addr), 40'(ead));
    chk(disp_right == right, req, 40'(disp_right), 40'(right));
  endtask

  task automatic done_pulse();
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
  endtask

  task automatic jump(input logic [11:0] t, input bit r, input bit with_done);
    exec_jump   = 1'b1;
    jump_target = t;
    jump_right  = r;
    exec_done   = with_done;
    @(negedge clk);
    exec_jump = 1'b0;
    exec_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int rc;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(disp_valid == 1'b0, "R2", 40'(disp_valid), 40'd0);
    chk(pc == 12'd0, "R2", 40'(pc), 40'd0);
    rst_n = 1'b1;
    chk(mem_rd == 1'b1 && mem_addr == 12'd0, "R2", 40'({mem_rd, mem_addr}), 40'h1000);

    // R1 R4 R5 R6: sequential sweep
    for (int w = 0; w < 40; w++) begin
      expect_disp(12'(w), 1'b0, "R4");
      chk(pc == 12'(w + 1), "R6", 40'(pc), 40'(w + 1));
      if (w == 5) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(disp_valid && disp_op == l_op(12'(w)) && disp_addr == l_ad(12'(w)),
              "R9", 40'({disp_valid, disp_op, disp_addr}), 40'({1'b1, l_op(12'(w)), l_ad(12'(w))}));
        end
      end
      rc = reads;
      done_pulse();
      expect_disp(12'(w), 1'b1, "R5");
      chk(reads == rc, "R5", 40'(reads), 40'(rc));
      done_pulse();
    end

    // R7 R6: jump to left of 4094, run across the wrap
    expect_disp(12'd40, 1'b0, "R4");
    jump(12'd4094, 1'b0, 1'b0);
    expect_disp(12'd4094, 1'b0, "R7");
    chk(pc == 12'd4095, "R6", 40'(pc), 40'd4095);
    done_pulse();
    expect_disp(12'd4094, 1'b1, "R7");
    done_pulse();
    expect_disp(12'd4095, 1'b0, "R6");
    done_pulse();
    expect_disp(12'd4095, 1'b1, "R6");
    done_pulse();
    expect_disp(12'd0, 1'b0, "R6");
    chk(pc == 12'd1, "R6", 40'(pc), 40'd1);

    // R8: jump to right half
    rc = reads;
    jump(12'd100, 1'b1, 1'b0);
    expect_disp(12'd100, 1'b1, "R8");
    chk(reads == rc + 1, "R8", 40'(reads), 40'(rc + 1));
    done_pulse();
    expect_disp(12'd101, 1'b0, "R8");
    done_pulse();
    expect_disp(12'd101, 1'b1, "R5");

    // R7: jump from right half, buffer must not leak
    jump(12'd200, 1'b0, 1'b0);
    expect_disp(12'd200, 1'b0, "R7");

    // R10: jump and done together while buffer holds the right half
    jump(12'd300, 1'b1, 1'b1);
    chk(disp_valid == 1'b0, "R10", 40'(disp_valid), 40'd0);
    expect_disp(12'd300, 1'b1, "R10");
    done_pulse();
    expect_disp(12'd301, 1'b0, "R10");

    // R8 sweep of right-half jumps across the address space
    for (int i = 0; i < 16; i++) begin
      logic [11:0] t;
      t = (i == 15) ? 12'd4095 : 12'(i * 273);
      jump(t, 1'b1, 1'b0);
      expect_disp(t, 1'b1, "R8");
      chk(pc == t + 12'd1, "R6", 40'(pc), 40'(t + 12'd1));
      done_pulse();
      expect_disp(t + 12'd1, 1'b0, "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule